// File: doc/BRIEF.md
# Periodic Descriptor Scan Scheduler

This block walks a buffer of up to 32 interrupt transfer descriptor slots once per frame. On each frame tick it starts at slot 0 and moves upward one slot at a time. Slots whose skip bit is set are passed over. Each remaining slot is handed, one at a time, to a transaction engine through a valid/ready request that carries the slot index. The scheduler then waits for that slot's response before it moves on. The walk ends after the first slot flagged in the last-slot mask, or after the top slot when no flag is set. It then emits a single-cycle pulse that tells the next stage to begin the asynchronous-list phase.

Slots that completed with an acknowledge are gathered in a shadow mask during the walk. At the next frame tick that shadow is ORed into a host-visible done mask. The host programs the skip and last masks and reads the done mask through a small address/data port. Reading the done mask clears it. A frame tick that lands while a walk is still running aborts the walk, counts an overrun and restarts from slot 0.

Top module: `pdscan_sched`

## Requirements
- R1: After reset the skip, last and done masks read as zero, `req_valid` and `async_start` are low and `ovr_cnt` is zero.
- R2: Reads at address 0x17 return the done mask, at 0x18 the skip mask and at 0x19 the last mask. Writes at 0x98 load the skip mask and writes at 0x99 load the last mask. Any other read address, including the write addresses, returns zero. Bit i of every mask belongs to slot i.
- R3: After each frame tick, requests are issued in strictly ascending slot order starting from slot 0.
- R4: A slot whose skip bit is 1 is never requested. Once its skip bit is written back to 0, the slot is requested on the next walk.
- R5: A slot's done bit becomes 1 only if the slot was requested and its response had `rsp_ack` = 1. A response with `rsp_ack` = 0 leaves the bit at 0.
- R6: The done mask changes only on a frame tick, which ORs in the shadow, or on a read of 0x17. Results of a walk are invisible until the following tick.
- R7: A read of 0x17 returns the current done mask and clears it. If a frame tick falls in the same cycle, the bits merged by that tick survive the clear.
- R8: The walk stops after the lowest slot whose last bit is 1 has finished. `async_start` is then high for exactly one cycle.
- R9: With no last bit set, the walk covers every non-skipped slot through slot 31 and then pulses `async_start` once.
- R10: A last bit on a skipped slot ends the walk at that slot without requesting it.
- R11: `req_valid` and `req_slot` stay steady until `req_ready`. At most one request is outstanding, and the next request follows only after `rsp_done`.
- R12: A frame tick during a walk increments the saturating `ovr_cnt`, drops the walk and restarts at slot 0. A tick while the scheduler is idle does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame start strobe |
| hr_en | input | 1 | Host register access strobe |
| hr_wr | input | 1 | 1 = write, 0 = read |
| hr_addr | input | 8 | Host register address |
| hr_wdata | input | 32 | Host write data |
| hr_rdata | output | 32 | Host read data, valid in the read cycle |
| req_valid | output | 1 | Slot request to the transaction engine |
| req_ready | input | 1 | Engine accepts the request |
| req_slot | output | 5 | Index of the requested slot |
| rsp_done | input | 1 | Engine finished the outstanding slot |
| rsp_ack | input | 1 | Finished slot was acknowledged |
| async_start | output | 1 | One-cycle hand-off to the asynchronous list |
| ovr_cnt | output | 8 | Saturating count of frame overruns |

## Verification
The tick that merges the shadow into the done mask can coincide with a host read that clears the same mask. The bench sets this up by leaving a known bit in the visible mask and a different bit in the shadow. It then raises the tick and a 0x17 read together. It checks that the read data in that cycle shows only the old bit and that a follow-up read shows only the new one. A second collision, a tick arriving mid-walk, is judged from the slot sequence the engine model records after the abort.

// File: rtl/pds_pkg.sv
package pds_pkg;

  localparam int REG_W = 32;

  localparam logic [7:0] ADR_DONE_RD = 8'h17;
  localparam logic [7:0] ADR_SKIP_RD = 8'h18;
  localparam logic [7:0] ADR_LAST_RD = 8'h19;
  localparam logic [7:0] ADR_SKIP_WR = 8'h98;
  localparam logic [7:0] ADR_LAST_WR = 8'h99;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_EVAL = 2'd1,
    W_REQ  = 2'd2,
    W_WAIT = 2'd3
  } walk_st_e;

  typedef struct packed {
    logic rd_done;
    logic wr_skip;
    logic wr_last;
  } host_op_t;

endpackage

// File: rtl/pds_rst_sync.sv
module pds_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pds_regs.sv
module pds_regs
  import pds_pkg::*;
#(
  parameter int NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hr_en,
  input  logic             hr_wr,
  input  logic [7:0]       hr_addr,
  input  logic [REG_W-1:0] hr_wdata,
  output logic [REG_W-1:0] hr_rdata,
  input  logic             tick,
  input  logic [NSLOT-1:0] shadow,
  output logic [NSLOT-1:0] skip_mask,
  output logic [NSLOT-1:0] last_mask,
  output logic [NSLOT-1:0] done_mask,
  output logic             rd_clr
);

  host_op_t         op;
  logic [NSLOT-1:0] skip_q, skip_d;
  logic [NSLOT-1:0] last_q, last_d;
  logic [NSLOT-1:0] done_q, done_d;
  logic             done_en;

  // access decode
  always_comb begin
    op.rd_done = hr_en && !hr_wr && (hr_addr == ADR_DONE_RD);
    op.wr_skip = hr_en &&  hr_wr && (hr_addr == ADR_SKIP_WR);
    op.wr_last = hr_en &&  hr_wr && (hr_addr == ADR_LAST_WR);
  end

  // next-state
  always_comb begin
    skip_d  = hr_wdata[NSLOT-1:0];
    last_d  = hr_wdata[NSLOT-1:0];
    done_en = op.rd_done || tick;
    // clear on read first, then OR in the bits arriving with the tick
    done_d  = (op.rd_done ? '0 : done_q) | (tick ? shadow : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
      last_q <= '0;
      done_q <= '0;
    end else begin
      if (op.wr_skip) skip_q <= skip_d;
      if (op.wr_last) last_q <= last_d;
      if (done_en)    done_q <= done_d;
    end
  end

  // read mux, zero-extended to the register width
  always_comb begin
    hr_rdata = '0;
    if (hr_en && !hr_wr) begin
      unique case (hr_addr)
        ADR_DONE_RD: hr_rdata = REG_W'(done_q);
        ADR_SKIP_RD: hr_rdata = REG_W'(skip_q);
        ADR_LAST_RD: hr_rdata = REG_W'(last_q);
        default:     hr_rdata = '0;
      endcase
    end
  end

  assign skip_mask = skip_q;
  assign last_mask = last_q;
  assign done_mask = done_q;
  assign rd_clr    = op.rd_done;

endmodule

// File: rtl/pds_collect.sv
module pds_collect #(
  parameter int NSLOT = 32,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rec_valid,
  input  logic [SW-1:0]    rec_slot,
  input  logic             rec_ack,
  output logic [NSLOT-1:0] shadow
);

  // one enabled flop per slot: set by an acknowledged completion,
  // emptied by the frame tick that hands it to the visible mask
  for (genvar g = 0; g < NSLOT; g++) begin : g_bit
    logic hit;
    logic en;
    logic d;
    logic sh_q;

    always_comb begin
      hit = rec_valid && rec_ack && (rec_slot == SW'(g));
      en  = tick || hit;
      d   = !tick;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= 1'b0;
      end else if (en) begin
        sh_q <= d;
      end
    end

    assign shadow[g] = sh_q;
  end

endmodule

// File: rtl/pds_walker.sv
module pds_walker
  import pds_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int OVR_W = 8,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [NSLOT-1:0] skip_mask,
  input  logic [NSLOT-1:0] last_mask,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [SW-1:0]    req_slot,
  input  logic             rsp_done,
  input  logic             rsp_ack,
  output logic             rec_valid,
  output logic [SW-1:0]    rec_slot,
  output logic             rec_ack,
  output logic             handoff,
  output logic [OVR_W-1:0] ovr_cnt,
  output logic             busy
);

  localparam logic [SW-1:0]    TOP_SLOT = SW'(NSLOT - 1);
  localparam logic [OVR_W-1:0] OVR_MAX  = '1;

  walk_st_e         st_q, st_d;
  logic [SW-1:0]    slot_q, slot_d;
  logic             hand_q, hand_d;
  logic [OVR_W-1:0] ovr_q, ovr_d;
  logic             ovr_en, slot_en;
  logic             at_end, skipped;

  always_comb begin
    at_end  = last_mask[slot_q] || (slot_q == TOP_SLOT);
    skipped = skip_mask[slot_q];
  end

  // next-state
  always_comb begin
    st_d      = st_q;
    slot_d    = slot_q;
    hand_d    = 1'b0;
    ovr_d     = ovr_q;
    ovr_en    = 1'b0;
    rec_valid = 1'b0;

    if (tick) begin
      // a new frame always restarts the walk; count it if one was running
      st_d   = W_EVAL;
      slot_d = '0;
      if (st_q != W_IDLE && ovr_q != OVR_MAX) begin
        ovr_d  = ovr_q + 1'b1;
        ovr_en = 1'b1;
      end
    end else begin
      unique case (st_q)
        W_IDLE: ;
        W_EVAL: begin
          if (!skipped) begin
            st_d = W_REQ;
          end else if (at_end) begin
            st_d   = W_IDLE;
            hand_d = 1'b1;
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end
        W_REQ: begin
          if (req_ready) st_d = W_WAIT;
        end
        W_WAIT: begin
          if (rsp_done) begin
            rec_valid = 1'b1;
            if (at_end) begin
              st_d   = W_IDLE;
              hand_d = 1'b1;
            end else begin
              st_d   = W_EVAL;
              slot_d = slot_q + 1'b1;
            end
          end
        end
        default: st_d = W_IDLE;
      endcase
    end
    slot_en = (slot_d != slot_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      slot_q <= '0;
      hand_q <= 1'b0;
      ovr_q  <= '0;
    end else begin
      st_q   <= st_d;
      hand_q <= hand_d;
      if (slot_en) slot_q <= slot_d;
      if (ovr_en)  ovr_q  <= ovr_d;
    end
  end

  assign req_valid = (st_q == W_REQ);
  assign req_slot  = slot_q;
  assign rec_slot  = slot_q;
  assign rec_ack   = rsp_ack;
  assign handoff   = hand_q;
  assign ovr_cnt   = ovr_q;
  assign busy      = (st_q != W_IDLE);

endmodule

// File: rtl/pdscan_sched.sv
module pdscan_sched
  import pds_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int OVR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_tick,
  input  logic                     hr_en,
  input  logic                     hr_wr,
  input  logic [7:0]               hr_addr,
  input  logic [31:0]              hr_wdata,
  output logic [31:0]              hr_rdata,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [$clog2(NSLOT)-1:0] req_slot,
  input  logic                     rsp_done,
  input  logic                     rsp_ack,
  output logic                     async_start,
  output logic [OVR_W-1:0]         ovr_cnt
);

  localparam int SW = $clog2(NSLOT);

  logic             rst_sync_n;
  logic [NSLOT-1:0] skip_mask;
  logic [NSLOT-1:0] last_mask;
  logic [NSLOT-1:0] done_mask;
  logic [NSLOT-1:0] shadow;
  logic             rd_clr;
  logic             rec_valid;
  logic [SW-1:0]    rec_slot;
  logic             rec_ack;
  logic             walk_busy;

  pds_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pds_regs #(.NSLOT(NSLOT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hr_en     (hr_en),
    .hr_wr     (hr_wr),
    .hr_addr   (hr_addr),
    .hr_wdata  (hr_wdata),
    .hr_rdata  (hr_rdata),
    .tick      (frame_tick),
    .shadow    (shadow),
    .skip_mask (skip_mask),
    .last_mask (last_mask),
    .done_mask (done_mask),
    .rd_clr    (rd_clr)
  );

  pds_walker #(.NSLOT(NSLOT), .OVR_W(OVR_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (frame_tick),
    .skip_mask (skip_mask),
    .last_mask (last_mask),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_slot  (req_slot),
    .rsp_done  (rsp_done),
    .rsp_ack   (rsp_ack),
    .rec_valid (rec_valid),
    .rec_slot  (rec_slot),
    .rec_ack   (rec_ack),
    .handoff   (async_start),
    .ovr_cnt   (ovr_cnt),
    .busy      (walk_busy)
  );

  pds_collect #(.NSLOT(NSLOT)) u_coll (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (frame_tick),
    .rec_valid (rec_valid),
    .rec_slot  (rec_slot),
    .rec_ack   (rec_ack),
    .shadow    (shadow)
  );

endmodule

// File: rtl/pdscan_sched_chk.sv
module pdscan_sched_chk #(
  parameter int NSLOT = 32,
  parameter int OVR_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_tick,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic [$clog2(NSLOT)-1:0] req_slot,
  input logic                     async_start,
  input logic                     rd_clr,
  input logic [NSLOT-1:0]         done_mask,
  input logic [OVR_W-1:0]         ovr_cnt,
  input logic                     walk_busy
);

  // R11: a request waits unchanged for ready
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !frame_tick) |=> (req_valid && $stable(req_slot)));

  // R11: accepted request leaves nothing pending on the request side
  p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !frame_tick) |=> !req_valid);

  // R6: visible done mask moves only on tick or read
  p_done_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !rd_clr) |=> $stable(done_mask));

  // R7: read without a tick empties the mask
  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !frame_tick) |=> (done_mask == '0));

  // R8: hand-off is a single-cycle pulse
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    async_start |=> !async_start);

  // R12: tick during a walk bumps the overrun count
  p_ovr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && walk_busy && (ovr_cnt != '1)) |=> (ovr_cnt == $past(ovr_cnt) + 1'b1));

  // R12: tick while idle leaves the count alone
  p_ovr_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!walk_busy) |=> $stable(ovr_cnt));

endmodule

bind pdscan_sched pdscan_sched_chk #(.NSLOT(NSLOT), .OVR_W(OVR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_tick  (frame_tick),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_slot    (req_slot),
  .async_start (async_start),
  .rd_clr      (rd_clr),
  .done_mask   (done_mask),
  .ovr_cnt     (ovr_cnt),
  .walk_busy   (walk_busy)
);

// File: tb/pdscan_sched_tb.sv
module pdscan_sched_tb;

  logic        clk;
  logic        rst_n;
  logic        frame_tick;
  logic        hr_en;
  logic        hr_wr;
  logic [7:0]  hr_addr;
  logic [31:0] hr_wdata;
  logic [31:0] hr_rdata;
  logic        req_valid;
  logic        req_ready;
  logic [4:0]  req_slot;
  logic        rsp_done;
  logic        rsp_ack;
  logic        async_start;
  logic [7:0]  ovr_cnt;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [31:0] ack_mask = '0;
  bit          engine_en = 1;
  int          log_s [0:4095];
  int          log_n = 0;
  int          hand_n = 0;

  // skip, last, ack
  localparam logic [95:0] VECS [0:5] = '{
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_00F0, 32'h0000_1000, 32'hFFFF_FFFF},
    {32'hAAAA_AAAA, 32'h0000_0000, 32'h0F0F_0F0F},
    {32'h0000_0020, 32'h0000_0020, 32'h0000_0000},
    {32'h0000_0000, 32'h8000_0001, 32'h0000_0001},
    {32'hFFFF_FFFE, 32'h0000_0000, 32'h0000_0000}
  };

  pdscan_sched u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_tick  (frame_tick),
    .hr_en       (hr_en),
    .hr_wr       (hr_wr),
    .hr_addr     (hr_addr),
    .hr_wdata    (hr_wdata),
    .hr_rdata    (hr_rdata),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_slot    (req_slot),
    .rsp_done    (rsp_done),
    .rsp_ack     (rsp_ack),
    .async_start (async_start),
    .ovr_cnt     (ovr_cnt)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // transaction engine model: accept, one idle cycle, respond
  initial begin
    req_ready = 0;
    rsp_done  = 0;
    rsp_ack   = 0;
    forever begin
      @(negedge clk);
      if (engine_en && req_valid) begin
        int s;
        s = int'(req_slot);
        if (log_n < 4096) log_s[log_n] = s;
        log_n++;
        req_ready = 1;
        @(negedge clk);
        req_ready = 0;
        @(negedge clk);
        rsp_done = 1;
        rsp_ack  = ack_mask[s];
        @(negedge clk);
        rsp_done = 0;
        rsp_ack  = 0;
      end
    end
  end

  // hand-off monitor
  initial begin
    forever begin
      @(negedge clk);
      if (async_start) hand_n++;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hr_en = 1; hr_wr = 1; hr_addr = a; hr_wdata = d;
    @(negedge clk);
    hr_en = 0; hr_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    hr_en = 1; hr_wr = 0; hr_addr = a;
    #1 d = hr_rdata;
    @(negedge clk);
    hr_en = 0;
  endtask

  task automatic tick(output int base);
    @(negedge clk);
    frame_tick = 1;
    @(negedge clk);
    frame_tick = 0;
    base = log_n;
  endtask

  task automatic wait_hand(string req);
    int h0 = hand_n;
    int n  = 0;
    while (hand_n == h0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "hand-off seen", 32'(hand_n - h0), 32'd1);
  endtask

  task automatic flush();
    int b;
    logic [31:0] d;
    wr(8'h98, 32'hFFFF_FFFF);
    wr(8'h99, 32'h0);
    tick(b);
    wait_hand("R9");
    rd(8'h17, d);
  endtask

  task automatic run_scan(logic [31:0] sk, logic [31:0] ls, logic [31:0] ak, string req);
    int e [32];
    int en = 0;
    int mism = 0;
    int base;
    int h0;
    logic [31:0] ed = '0;
    logic [31:0] d;
    for (int i = 0; i < 32; i++) begin
      if (!sk[i]) begin
        e[en] = i;
        en++;
        if (ak[i]) ed[i] = 1'b1;
      end
      if (ls[i]) break;
    end
    wr(8'h98, sk);
    wr(8'h99, ls);
    ack_mask = ak;
    h0 = hand_n;
    tick(base);
    wait_hand(req);
    repeat (4) @(negedge clk);
    chk("R8", "single hand-off pulse", 32'(hand_n - h0), 32'd1);
    chk(req, "R3 issue count", 32'(log_n - base), 32'(en));
    for (int k = 0; k < en; k++) begin
      if (base + k >= 4096 || log_s[base + k] != e[k]) mism++;
    end
    chk("R3", "issue order mismatches", 32'(mism), 32'd0);
    rd(8'h17, d);
    chk("R6", "done before next tick", d, 32'h0);
    wr(8'h98, 32'hFFFF_FFFF);
    wr(8'h99, 32'h0);
    tick(base);
    wait_hand(req);
    rd(8'h17, d);
    chk("R5", "done after tick", d, ed);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    frame_tick = 0; hr_en = 0; hr_wr = 0; hr_addr = '0; hr_wdata = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    rd(8'h17, d); chk("R1", "done reset", d, 32'h0);
    rd(8'h18, d); chk("R1", "skip reset", d, 32'h0);
    rd(8'h19, d); chk("R1", "last reset", d, 32'h0);
    chk("R1", "req_valid reset", 32'(req_valid), 32'h0);
    chk("R1", "async_start reset", 32'(async_start), 32'h0);
    chk("R1", "ovr_cnt reset", 32'(ovr_cnt), 32'h0);

    // register map
    wr(8'h98, 32'h1234_5678);
    rd(8'h18, d); chk("R2", "skip readback", d, 32'h1234_5678);
    wr(8'h99, 32'h0001_0000);
    rd(8'h19, d); chk("R2", "last readback", d, 32'h0001_0000);
    rd(8'h98, d); chk("R2", "write address reads zero", d, 32'h0);
    rd(8'h20, d); chk("R2", "unmapped reads zero", d, 32'h0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      string tg;
      case (v)
        0: tg = "R9";
        1: tg = "R8";
        2: tg = "R5";
        3: tg = "R10";
        4: tg = "R8";
        default: tg = "R4";
      endcase
      run_scan(VECS[v][95:64], VECS[v][63:32], VECS[v][31:0], tg);
    end

    // R4: skipped then re-enabled slot
    run_scan(32'h0000_0008, 32'h0000_0010, 32'h0000_0008, "R4");
    run_scan(32'h0000_0000, 32'h0000_0010, 32'h0000_0008, "R4");

    // R7: tick and clearing read in the same cycle
    wr(8'h98, 32'hFFFF_FFFC);
    wr(8'h99, 32'h0);
    ack_mask = 32'h1;
    tick(base);
    wait_hand("R7");
    ack_mask = 32'h2;
    tick(base);
    wait_hand("R7");
    @(negedge clk);
    frame_tick = 1; hr_en = 1; hr_wr = 0; hr_addr = 8'h17;
    #1 d = hr_rdata;
    @(negedge clk);
    frame_tick = 0; hr_en = 0;
    chk("R7", "read data at collision", d, 32'h1);
    rd(8'h17, d);
    chk("R7", "new bits kept after collision", d, 32'h2);
    wait_hand("R7");
    flush();

    // R11: request held while engine stalls
    engine_en = 0;
    wr(8'h98, 32'h0);
    wr(8'h99, 32'h1);
    ack_mask = 32'h1;
    tick(base);
    repeat (10) @(negedge clk);
    chk("R11", "req_valid held", 32'(req_valid), 32'h1);
    chk("R11", "req_slot held", 32'(req_slot), 32'h0);
    engine_en = 1;
    wait_hand("R11");
    flush();

    // R12: overrun restarts at slot 0
    chk("R12", "no overrun yet", 32'(ovr_cnt), 32'h0);
    wr(8'h98, 32'h0);
    wr(8'h99, 32'h0);
    ack_mask = 32'hFFFF_FFFF;
    tick(base);
    repeat (30) @(negedge clk);
    tick(base);
    chk("R12", "overrun counted", 32'(ovr_cnt), 32'h1);
    wait_hand("R12");
    chk("R12", "restart first slot", 32'(log_s[base]), 32'h0);
    chk("R12", "restart issue count", 32'(log_n - base), 32'd32);
    flush();
    chk("R12", "idle ticks not counted", 32'(ovr_cnt), 32'h1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule